// File: doc/BRIEF.md
# Bit Set/Clear Read-Modify-Write Engine

This block changes one bit of a byte-wide data RAM. It takes a command made of an operation, a base byte address and a bit number. It turns the bit number into a byte address and a bit position, reads that byte, forces the chosen bit to 1 or to 0, and writes the byte back. When the write is done it raises a one-cycle done pulse. With that pulse it returns the value the bit had before the change, so software can use the block as a test-and-set primitive.

Bit numbers come in two forms. The first is a long bit offset of up to 64K bits, which reaches 8 KB above the base byte. The second is a direct form, where the base is the byte itself and only a 0–7 bit index counts. The RAM is a synchronous single-port byte memory. It is driven by a request line and a write-enable line, and read data appears in the cycle after a read request.

Top module: `bit_rmw_engine`

## Requirements
- R1: With cmdOp = 1 (set), the byte written back has the selected bit equal to 1.
- R2: With cmdOp = 0 (clear), the byte written back has the selected bit equal to 0.
- R3: Every other bit of the written byte equals the byte that was read from the same address.
- R4: With cmdDirect = 0, the byte address is cmdBase + floor(cmdBitNum / 8). The bit position is cmdBitNum mod 8, and position 0 is the least significant bit. A bit number below 8 selects a bit in the base byte itself.
- R5: With cmdDirect = 1, the byte address is cmdBase and the bit position is cmdBitNum[2:0]. Bits cmdBitNum[OFFS_W-1:3] have no effect.
- R6: A command is accepted on a rising edge where cmdValid = 1 and busy = 0. In the next cycle there is one read request (memReq = 1, memWe = 0). In the cycle after that there is one write request (memReq = 1, memWe = 1) to the same address.
- R7: done is high for exactly the one cycle after the write request. In that cycle priorBit holds the selected bit's value from before the command.
- R8: busy is high during the read and write cycles and low otherwise. A cmdValid seen while busy = 1 is ignored and changes no memory byte.
- R9: The byte address wraps modulo 2^ADDR_W when base plus byte offset goes beyond the RAM.
- R10: After reset, busy, done and memReq are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command present |
| cmdOp | input | 1 | 1 = set bit, 0 = clear bit |
| cmdDirect | input | 1 | 1 = byte address plus 0–7 index, 0 = long bit offset |
| cmdBase | input | ADDR_W | Base byte address |
| cmdBitNum | input | OFFS_W | Bit offset, or bit index in its low 3 bits |
| busy | output | 1 | Command in progress; new commands ignored |
| done | output | 1 | One-cycle completion pulse |
| priorBit | output | 1 | Value of the bit before the command, valid with done |
| memReq | output | 1 | RAM access request |
| memWe | output | 1 | RAM write enable (with memReq) |
| memAddr | output | ADDR_W | RAM byte address |
| memWdata | output | 8 | RAM write data |
| memRdata | input | 8 | RAM read data, one cycle after a read request |

## Verification
The bench builds the engine with ADDR_W = 10, which gives a 1 KB RAM, and with the default 16-bit offset. A full 64K-bit offset then runs far past the end of memory, so the wrap of the byte address can be reached from ordinary commands. A base near the top of memory combined with the largest offset lands on a known byte below the base. Direct-mode commands are given high offset bits that would point to a different byte in long mode, so any leak of those bits shows up as a wrong address.

// File: rtl/bit_rmw_pkg.sv
package bit_rmw_pkg;
  typedef enum logic {
    OP_CLEAR = 1'b0,
    OP_SET   = 1'b1
  } bitOpE;

  // strobes from control to datapath
  typedef struct packed {
    logic load;   // capture a new command
    logic rdEn;   // issue RAM read
    logic wrEn;   // issue RAM write, capture prior bit
  } dpStrobeS;
endpackage

// File: rtl/bit_rmw_ctrl.sv
module bit_rmw_ctrl
  import bit_rmw_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     cmdValid,
  output dpStrobeS strb,
  output logic     busy,
  output logic     done
);
  typedef enum logic [1:0] {S_IDLE, S_READ, S_WRITE} stateE;
  stateE state, stateNext;

  always_comb begin
    stateNext = state;
    case (state)
      S_IDLE:  if (cmdValid) stateNext = S_READ;
      S_READ:  stateNext = S_WRITE;
      S_WRITE: stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      done  <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= (state == S_WRITE);
    end
  end

  always_comb begin
    strb.load = (state == S_IDLE) && cmdValid;
    strb.rdEn = (state == S_READ);
    strb.wrEn = (state == S_WRITE);
  end

  assign busy = (state != S_IDLE);

  // R6
  read_then_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdEn |=> strb.wrEn);
  // R7
  done_after_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrEn |=> (done && !busy));
  // R8
  busy_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !strb.wrEn) |=> busy);
  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
endmodule

// File: rtl/bit_rmw_dp.sv
module bit_rmw_dp
  import bit_rmw_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int OFFS_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobeS          strb,
  input  logic              cmdOp,
  input  logic              cmdDirect,
  input  logic [ADDR_W-1:0] cmdBase,
  input  logic [OFFS_W-1:0] cmdBitNum,
  input  logic [7:0]        memRdata,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWdata,
  output logic              priorBit
);
  localparam int POS_W      = 3;
  localparam int BYTE_OFF_W = OFFS_W - POS_W;

  logic [ADDR_W-1:0] offExt;
  logic [ADDR_W-1:0] addrReg;
  logic [POS_W-1:0]  posReg;
  bitOpE             opReg;
  logic [7:0]        maskVec;

  // fit byte offset to the RAM address width (sum wraps modulo 2^ADDR_W)
  generate
    if (ADDR_W > BYTE_OFF_W) begin : g_widen
      assign offExt = {{(ADDR_W-BYTE_OFF_W){1'b0}}, cmdBitNum[OFFS_W-1:POS_W]};
    end else if (ADDR_W == BYTE_OFF_W) begin : g_same
      assign offExt = cmdBitNum[OFFS_W-1:POS_W];
    end else begin : g_trunc
      assign offExt = cmdBitNum[POS_W+ADDR_W-1:POS_W];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg  <= '0;
      posReg   <= '0;
      opReg    <= OP_CLEAR;
      priorBit <= 1'b0;
    end else begin
      if (strb.load) begin
        addrReg <= cmdDirect ? cmdBase : (cmdBase + offExt);
        posReg  <= cmdBitNum[POS_W-1:0];
        opReg   <= bitOpE'(cmdOp);
      end
      if (strb.wrEn) priorBit <= memRdata[posReg];
    end
  end

  assign maskVec  = 8'(1) << posReg;
  assign memReq   = strb.rdEn | strb.wrEn;
  assign memWe    = strb.wrEn;
  assign memAddr  = addrReg;
  assign memWdata = (opReg == OP_SET) ? (memRdata | maskVec) : (memRdata & ~maskVec);

  // R3
  one_bit_change_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> ($countones(memWdata ^ memRdata) <= 1));
  // R6
  same_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (memAddr == $past(memAddr)));
  // R1
  set_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && opReg == OP_SET) |-> memWdata[posReg]);
  // R2
  clear_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && opReg == OP_CLEAR) |-> !memWdata[posReg]);
endmodule

// File: rtl/bit_rmw_engine.sv
module bit_rmw_engine
  import bit_rmw_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int OFFS_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic              cmdOp,
  input  logic              cmdDirect,
  input  logic [ADDR_W-1:0] cmdBase,
  input  logic [OFFS_W-1:0] cmdBitNum,
  output logic              busy,
  output logic              done,
  output logic              priorBit,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWdata,
  input  logic [7:0]        memRdata
);
  dpStrobeS strb;

  bit_rmw_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid),
    .strb(strb), .busy(busy), .done(done)
  );

  bit_rmw_dp #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .cmdOp(cmdOp), .cmdDirect(cmdDirect), .cmdBase(cmdBase), .cmdBitNum(cmdBitNum),
    .memRdata(memRdata), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .priorBit(priorBit)
  );

  // R8
  req_only_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> busy);
  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !memReq);
endmodule

// File: tb/bit_rmw_engine_bench.sv
module bit_rmw_engine_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;
  localparam int OW = 16;
  localparam int MEM_N = 1 << AW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0, cmdOp = 1'b0, cmdDirect = 1'b0;
  logic [AW-1:0] cmdBase = '0;
  logic [OW-1:0] cmdBitNum = '0;
  logic busy, done, priorBit, memReq, memWe;
  logic [AW-1:0] memAddr;
  logic [7:0] memWdata;
  logic [7:0] memRdata = '0;

  logic [7:0] ram [MEM_N];
  int shadow [MEM_N];
  int nChecks = 0, nFails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bit_rmw_engine #(.ADDR_W(AW), .OFFS_W(OW)) u_bit_rmw_engine (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdDirect(cmdDirect),
    .cmdBase(cmdBase), .cmdBitNum(cmdBitNum), .busy(busy), .done(done),
    .priorBit(priorBit), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata)
  );

  // synchronous byte RAM, read data one cycle after the request
  always @(posedge clk) begin
    if (memReq) begin
      if (memWe) ram[memAddr] <= memWdata;
      else       memRdata <= ram[memAddr];
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  endtask

  // one command, compared against the model on every clock; junk drives cmdValid while busy
  task automatic run_cmd(input bit op, input bit direct, input int base, input int bitNum,
                         input bit junk);
    int expAddr, pos, expByte, expPrior;
    expAddr = direct ? base : (base + (bitNum / 8)) % MEM_N;
    pos = direct ? (bitNum % 8) : (bitNum % 8);
    expPrior = (shadow[expAddr] >> pos) & 1;
    expByte = op ? (shadow[expAddr] | (1 << pos)) : (shadow[expAddr] & ~(1 << pos));
    cmdValid = 1; cmdOp = op; cmdDirect = direct;
    cmdBase = AW'(base); cmdBitNum = OW'(bitNum);
    @(posedge clk); #1;
    if (junk) begin
      cmdOp = ~op; cmdDirect = 1; cmdBase = AW'(expAddr ^ 1); cmdBitNum = 16'h0005;
    end else cmdValid = 0;
    @(negedge clk);
    check(busy === 1'b1, "R8 busy in read", int'(busy), 1);
    check(memReq === 1'b1 && memWe === 1'b0, "R6 read request", {memReq, memWe}, 2);
    check(memAddr === AW'(expAddr), direct ? "R5 direct address" : "R4 R9 byte address",
          int'(memAddr), expAddr);
    @(negedge clk);
    check(memReq === 1'b1 && memWe === 1'b1, "R6 write request", {memReq, memWe}, 3);
    check(memAddr === AW'(expAddr), "R6 write address", int'(memAddr), expAddr);
    check(memWdata === 8'(expByte), op ? "R1 R3 set data" : "R2 R3 clear data",
          int'(memWdata), expByte);
    @(negedge clk);
    cmdValid = 0;
    check(done === 1'b1 && busy === 1'b0, "R7 done pulse", {done, busy}, 2);
    check(priorBit === expPrior[0], "R7 prior bit", int'(priorBit), expPrior);
    check(memReq === 1'b0, "R8 no request after write", int'(memReq), 0);
    shadow[expAddr] = expByte;
    check(int'(ram[expAddr]) == expByte, "R3 stored byte", int'(ram[expAddr]), expByte);
    if (junk) check(int'(ram[expAddr ^ 1]) == shadow[expAddr ^ 1], "R8 ignored while busy",
                    int'(ram[expAddr ^ 1]), shadow[expAddr ^ 1]);
  endtask

  initial begin
    for (int i = 0; i < MEM_N; i++) begin
      ram[i] = 8'((i * 37 + 5) & 8'hff);
      shadow[i] = (i * 37 + 5) & 8'hff;
    end
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    @(negedge clk);
    // R10
    check(busy === 1'b0 && done === 1'b0 && memReq === 1'b0, "R10 reset state",
          {busy, done, memReq}, 0);
    run_cmd(1, 0, 100, 42, 0);       // R4 bit 42 -> byte base+5, bit 2
    run_cmd(0, 0, 7, 0, 0);          // R2 R4 bit 0 of base byte
    run_cmd(1, 0, 7, 7, 0);          // R1 bit 7 of base byte
    run_cmd(1, 0, 7, 7, 0);          // R7 already set: prior 1
    run_cmd(0, 1, 200, 16'hFFF3, 0); // R5 high bits ignored
    run_cmd(1, 1, 201, 16'h8004, 0); // R5
    run_cmd(1, 0, 1000, 16'hFFFF, 0);// R9 wraps to byte 999, bit 7
    run_cmd(0, 0, 1020, 100, 0);     // R9 wraps to byte 8
    run_cmd(1, 0, 300, 77, 1);       // R8 junk command while busy
    for (int k = 0; k < 8; k++)
      run_cmd(k[0], k[1], 50 + k * 9, k * 1234 + 3, k[2]);
    @(negedge clk);
    // R8 idle after last done
    check(busy === 1'b0 && done === 1'b0, "R8 idle after command", {busy, done}, 0);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end
endmodule